// File: doc/BRIEF.md
# Dual and Fly-By DMA Channel

This block is one DMA channel that moves a programmed number of bytes over a simple request/ready bus, on the master side. Software loads a source pointer, a destination pointer, a byte count, an operand size, a mode and two address-type codes, then pulses `start`. Each element transfer is paced by the peripheral request line `dreq`. A single request is latched and stays latched until the transfer it paces has finished on the bus. Any further request edges that arrive while one is latched are dropped.

In dual-address mode the channel reads one operand at the source pointer into a staging register. It then writes that operand to the destination pointer. In the two fly-by modes the staging register is not used: one bus cycle moves the operand directly between the peripheral and memory. The acknowledge strobe `dack` marks every bus cycle that addresses the peripheral side. The channel advances its memory-side pointers and counts the bytes down. When the count is exhausted without a bus error, it sets a done flag, which can drive an interrupt through a mask. A bus error aborts the job and sets an error flag instead.

Top module: `dfb_dma_chan`

## Requirements
- R1: A `start` pulse while idle latches the pointers, count, mode, size, address-type codes and side flags, makes `busy` high and clears `done` and `err`. A `start` while busy is ignored, and the running job keeps its original pointers.
- R2: A `start` with a byte count of zero sets `done` on the next clock with `busy` low and no bus cycle.
- R3: While busy, a `dreq` seen with no request latched latches one request. No bus cycle begins without a latched request. `dreq` seen while a request is latched is ignored. The latch clears when the last bus cycle of that transfer completes.
- R4: Mode code 00 (and 11) is dual-address. It makes a read (`bus_we`=0) at the source pointer with the source code on `bus_fc`. This is followed by a write (`bus_we`=1) at the destination pointer with the destination code, whose `bus_wdata` equals the `bus_rdata` captured by the read.
- R5: Size code 0, 1, 2, 3 means 1, 2, 4, 16 bytes, presented on `bus_size`. After each completed access to a memory side, that side's pointer advances by the size. A side flagged as peripheral keeps its address.
- R6: Each completed transfer lowers the count by the size, saturating at zero. The job ends when the count reaches zero, so it takes ceil(count/size) transfers.
- R7: `dack` is high during a dual-mode read whose source is a peripheral, during a dual-mode write whose destination is a peripheral, and during every fly-by cycle. It is high only while `bus_req` is high.
- R8: Mode 01 makes one write cycle at the destination pointer with the destination code. Mode 10 makes one read cycle at the source pointer with the source code. Both assert `dack`.
- R9: `done` is set when the count reaches zero with no bus error, and `busy` falls in the same clock. `irq` equals `done` AND `irq_en`.
- R10: `bus_err` sampled with `bus_req` aborts the job. `err` is set, `done` stays clear, `busy` falls and no further bus cycle occurs.
- R11: `clr_done` and `clr_err` held high for a clock clear the matching flag (write-one-to-clear).
- R12: Once raised, `bus_req`, `bus_addr`, `bus_we` and `bus_fc` stay unchanged until `bus_ready` or `bus_err` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job (one-clock pulse) |
| cfg_mode | input | 2 | 00/11 dual, 01 peripheral-to-memory fly-by, 10 memory-to-peripheral fly-by |
| cfg_size | input | 2 | Operand size code: 1, 2, 4, 16 bytes |
| cfg_src | input | AW | Initial source pointer |
| cfg_dst | input | AW | Initial destination pointer |
| cfg_count | input | CW | Byte count |
| cfg_src_fc | input | FCW | Address-type code for source accesses |
| cfg_dst_fc | input | FCW | Address-type code for destination accesses |
| cfg_src_mem | input | 1 | Dual mode: source is memory (1) or peripheral (0) |
| cfg_dst_mem | input | 1 | Dual mode: destination is memory (1) or peripheral (0) |
| irq_en | input | 1 | Interrupt mask for done |
| clr_done | input | 1 | Write-one-to-clear for done |
| clr_err | input | 1 | Write-one-to-clear for err |
| dreq | input | 1 | Peripheral transfer request |
| dack | output | 1 | Peripheral access strobe |
| bus_req | output | 1 | Bus cycle valid |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Bus address |
| bus_fc | output | FCW | Address-type code |
| bus_size | output | 2 | Operand size code |
| bus_wdata | output | DW | Write data from staging register |
| bus_rdata | input | DW | Read data |
| bus_ready | input | 1 | Cycle completes |
| bus_err | input | 1 | Cycle failed |
| busy | output | 1 | Job in progress |
| done | output | 1 | Job finished without error |
| err | output | 1 | Job aborted by bus error |
| irq | output | 1 | Masked done interrupt |

## Verification
The checker watches several rules on every clock:
- the bus handshake holds still until it completes;
- `dack` never appears outside a bus cycle;
- no cycle occurs while idle;
- `done` and `err` are never both set;
- `done` only falls under a clear or a start;
- the count never rises within a job.

Other behaviour needs the bench's scenarios with an independent model:
- the exact address sequences for each mode, size and side flag;
- the data carried from read to write;
- the number of transfers for a count that is not a multiple of the size;
- the dropping of a second request;
- the abort on error;
- the zero-count start.

// File: rtl/dfb_pkg.sv
package dfb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RD,
    ST_WR,
    ST_FLY
  } dfb_state_t;

  localparam logic [1:0] MODE_P2M = 2'b01;
  localparam logic [1:0] MODE_M2P = 2'b10;

  // operand size code to byte count
  function automatic logic [4:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd1;
      2'd1:    return 5'd2;
      2'd2:    return 5'd4;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/dfb_req_latch.sv
module dfb_req_latch (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic dreq,
  input  logic clear,
  output logic pending
);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      pending <= 1'b0;
    end else if (pending) begin
      if (clear) pending <= 1'b0;
    end else if (dreq) begin
      pending <= 1'b1;
    end
  end

endmodule

// File: rtl/dfb_addr_gen.sv
module dfb_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic [CW-1:0] ld_cnt,
  input  logic [4:0]    step,
  input  logic          adv_src,
  input  logic          adv_dst,
  input  logic          dec_cnt,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr,
  output logic [CW-1:0] cnt,
  output logic          last
);

  localparam int PADA = AW - 5;
  localparam int PADC = CW - 5;

  logic [AW-1:0] step_a;
  logic [CW-1:0] step_c;
  logic [CW-1:0] cnt_nxt;

  assign step_a  = {{PADA{1'b0}}, step};
  assign step_c  = {{PADC{1'b0}}, step};
  assign last    = (cnt <= step_c);
  assign cnt_nxt = last ? '0 : cnt - step_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_ptr <= '0;
      dst_ptr <= '0;
      cnt     <= '0;
    end else if (load) begin
      src_ptr <= ld_src;
      dst_ptr <= ld_dst;
      cnt     <= ld_cnt;
    end else begin
      if (adv_src) src_ptr <= src_ptr + step_a;
      if (adv_dst) dst_ptr <= dst_ptr + step_a;
      if (dec_cnt) cnt     <= cnt_nxt;
    end
  end

endmodule

// File: rtl/dfb_status.sv
module dfb_status (
  input  logic clk,
  input  logic rst,
  input  logic clear_all,
  input  logic set_done,
  input  logic set_err,
  input  logic clr_done,
  input  logic clr_err,
  input  logic irq_en,
  output logic done,
  output logic err,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (set_done)                  done <= 1'b1;
      else if (clear_all || clr_done) done <= 1'b0;
      if (set_err)                   err  <= 1'b1;
      else if (clear_all || clr_err)  err  <= 1'b0;
    end
  end

  assign irq = done & irq_en;

endmodule

// File: rtl/dfb_dma_chan.sv
module dfb_dma_chan
  import dfb_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int FCW = 3,
  parameter int DW  = 128
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [1:0]     cfg_mode,
  input  logic [1:0]     cfg_size,
  input  logic [AW-1:0]  cfg_src,
  input  logic [AW-1:0]  cfg_dst,
  input  logic [CW-1:0]  cfg_count,
  input  logic [FCW-1:0] cfg_src_fc,
  input  logic [FCW-1:0] cfg_dst_fc,
  input  logic           cfg_src_mem,
  input  logic           cfg_dst_mem,
  input  logic           irq_en,
  input  logic           clr_done,
  input  logic           clr_err,
  input  logic           dreq,
  output logic           dack,
  output logic           bus_req,
  output logic           bus_we,
  output logic [AW-1:0]  bus_addr,
  output logic [FCW-1:0] bus_fc,
  output logic [1:0]     bus_size,
  output logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  bus_rdata,
  input  logic           bus_ready,
  input  logic           bus_err,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic           irq
);

  dfb_state_t     state, state_n;
  logic [1:0]     mode_q, size_q;
  logic [FCW-1:0] sfc_q, dfc_q;
  logic           smem_q, dmem_q;
  logic [DW-1:0]  stage_q;

  logic          pending, last, fly, m2p;
  logic [AW-1:0] src_ptr, dst_ptr;
  logic [CW-1:0] cnt_q;
  logic          load, set_done, set_err, adv_src, adv_dst, dec_cnt, xfer_end, capture;

  assign fly  = (mode_q == MODE_P2M) || (mode_q == MODE_M2P);
  assign m2p  = (mode_q == MODE_M2P);
  assign busy = (state != ST_IDLE);

  always_comb begin
    state_n  = state;
    load     = 1'b0;
    set_done = 1'b0;
    set_err  = 1'b0;
    adv_src  = 1'b0;
    adv_dst  = 1'b0;
    dec_cnt  = 1'b0;
    xfer_end = 1'b0;
    capture  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          load = 1'b1;
          if (cfg_count == '0) set_done = 1'b1;
          else                 state_n  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (pending) state_n = fly ? ST_FLY : ST_RD;
      end
      ST_RD: begin
        if (bus_err) begin
          set_err  = 1'b1;
          xfer_end = 1'b1;
          state_n  = ST_IDLE;
        end else if (bus_ready) begin
          capture = 1'b1;
          adv_src = smem_q;
          state_n = ST_WR;
        end
      end
      ST_WR, ST_FLY: begin
        if (bus_err) begin
          set_err  = 1'b1;
          xfer_end = 1'b1;
          state_n  = ST_IDLE;
        end else if (bus_ready) begin
          if (state == ST_WR) begin
            adv_dst = dmem_q;
          end else begin
            adv_src = m2p;
            adv_dst = !m2p;
          end
          dec_cnt  = 1'b1;
          xfer_end = 1'b1;
          if (last) begin
            set_done = 1'b1;
            state_n  = ST_IDLE;
          end else begin
            state_n = ST_WAIT;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      mode_q  <= '0;
      size_q  <= '0;
      sfc_q   <= '0;
      dfc_q   <= '0;
      smem_q  <= 1'b0;
      dmem_q  <= 1'b0;
      stage_q <= '0;
    end else begin
      state <= state_n;
      if (load) begin
        mode_q <= cfg_mode;
        size_q <= cfg_size;
        sfc_q  <= cfg_src_fc;
        dfc_q  <= cfg_dst_fc;
        smem_q <= cfg_src_mem;
        dmem_q <= cfg_dst_mem;
      end
      if (capture) stage_q <= bus_rdata;
    end
  end

  dfb_req_latch u_req (
    .clk     (clk),
    .rst     (rst),
    .enable  (busy),
    .dreq    (dreq),
    .clear   (xfer_end),
    .pending (pending)
  );

  dfb_addr_gen #(.AW(AW), .CW(CW)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .ld_src  (cfg_src),
    .ld_dst  (cfg_dst),
    .ld_cnt  (cfg_count),
    .step    (size_bytes(size_q)),
    .adv_src (adv_src),
    .adv_dst (adv_dst),
    .dec_cnt (dec_cnt),
    .src_ptr (src_ptr),
    .dst_ptr (dst_ptr),
    .cnt     (cnt_q),
    .last    (last)
  );

  dfb_status u_stat (
    .clk       (clk),
    .rst       (rst),
    .clear_all (load),
    .set_done  (set_done),
    .set_err   (set_err),
    .clr_done  (clr_done),
    .clr_err   (clr_err),
    .irq_en    (irq_en),
    .done      (done),
    .err       (err),
    .irq       (irq)
  );

  assign bus_req   = (state == ST_RD) || (state == ST_WR) || (state == ST_FLY);
  assign bus_we    = (state == ST_WR) || ((state == ST_FLY) && !m2p);
  assign bus_addr  = ((state == ST_RD) || ((state == ST_FLY) && m2p)) ? src_ptr : dst_ptr;
  assign bus_fc    = ((state == ST_RD) || ((state == ST_FLY) && m2p)) ? sfc_q : dfc_q;
  assign bus_size  = size_q;
  assign bus_wdata = stage_q;
  assign dack      = ((state == ST_RD) && !smem_q) || ((state == ST_WR) && !dmem_q) ||
                     (state == ST_FLY);

endmodule

// File: rtl/dfb_dma_chan_chk.sv
module dfb_dma_chan_chk #(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int FCW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           clr_done,
  input logic           bus_req,
  input logic           bus_ready,
  input logic           bus_err,
  input logic [AW-1:0]  bus_addr,
  input logic           bus_we,
  input logic [FCW-1:0] bus_fc,
  input logic           dack,
  input logic           busy,
  input logic           done,
  input logic           err,
  input logic [CW-1:0]  cnt
);

  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ready && !bus_err) |=>
      (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_fc)));

  p_dack_in_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    dack |-> bus_req);

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_req);

  p_done_err_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

  p_done_clear_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> $past(clr_done || start));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> !busy);

  p_cnt_down_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (cnt <= $past(cnt)));

endmodule

bind dfb_dma_chan dfb_dma_chan_chk #(.AW(AW), .CW(CW), .FCW(FCW)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .clr_done  (clr_done),
  .bus_req   (bus_req),
  .bus_ready (bus_ready),
  .bus_err   (bus_err),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_fc    (bus_fc),
  .dack      (dack),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .cnt       (cnt_q)
);

// File: tb/test_dfb_dma_chan.sv
module test_dfb_dma_chan;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [1:0]   cfg_mode = '0, cfg_size = '0;
  logic [31:0]  cfg_src = '0, cfg_dst = '0;
  logic [15:0]  cfg_count = '0;
  logic [2:0]   cfg_src_fc = '0, cfg_dst_fc = '0;
  logic         cfg_src_mem = 1'b1, cfg_dst_mem = 1'b1;
  logic         irq_en = 1'b0, clr_done = 1'b0, clr_err = 1'b0, dreq = 1'b0;
  logic         dack, bus_req, bus_we, busy, done, err, irq;
  logic [31:0]  bus_addr;
  logic [2:0]   bus_fc;
  logic [1:0]   bus_size;
  logic [127:0] bus_wdata;
  logic [127:0] bus_rdata = '0;
  logic         bus_ready = 1'b0, bus_err = 1'b0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dfb_dma_chan i_dfb_dma_chan (
    .clk(clk), .rst(rst), .start(start), .cfg_mode(cfg_mode), .cfg_size(cfg_size),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_count(cfg_count),
    .cfg_src_fc(cfg_src_fc), .cfg_dst_fc(cfg_dst_fc),
    .cfg_src_mem(cfg_src_mem), .cfg_dst_mem(cfg_dst_mem),
    .irq_en(irq_en), .clr_done(clr_done), .clr_err(clr_err), .dreq(dreq),
    .dack(dack), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_fc(bus_fc), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err),
    .busy(busy), .done(done), .err(err), .irq(irq)
  );

  function automatic logic [127:0] pat(input logic [31:0] a);
    return {a, ~a, a ^ 32'h5A5A_C3C3, a + 32'h1357_9BDF};
  endfunction

  function automatic int nbytes(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : (c == 2'd2) ? 4 : 16;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  // serve one bus cycle; entered and left at a negedge
  task automatic serve(input string rq, input logic ewe, input logic [31:0] eaddr,
                       input logic [2:0] efc, input logic edack, input bit chk_wd,
                       input logic [127:0] ewd, input logic [1:0] esz, input bit give_err);
    int t = 0;
    while (!bus_req && t < 50) begin
      @(negedge clk);
      t++;
    end
    chk(bus_req == 1'b1, rq, "bus_req", bus_req, 1);
    chk(bus_addr == eaddr, rq, "addr", bus_addr, eaddr);
    chk(bus_we == ewe, rq, "we", bus_we, ewe);
    chk(bus_fc == efc, rq, "fc", bus_fc, efc);
    chk(dack == edack, "R7", "dack", dack, edack);
    chk(bus_size == esz, "R5", "size", bus_size, esz);
    if (chk_wd) chk(bus_wdata == ewd, "R4", "wdata", bus_wdata, ewd);
    repeat ($urandom_range(0, 2)) begin
      @(negedge clk);
      chk(bus_req && bus_addr == eaddr, "R12", "held", bus_addr, eaddr);
    end
    bus_rdata = pat(eaddr);
    bus_ready = !give_err;
    bus_err   = give_err;
    @(negedge clk);
    bus_ready = 1'b0;
    bus_err   = 1'b0;
  endtask

  task automatic run_job(input logic [1:0] md, input logic [1:0] sz,
                         input logic [31:0] src, input logic [31:0] dst,
                         input logic [15:0] cnt, input logic smem, input logic dmem,
                         input logic ie, input int err_at, input bit extra, input bit probe);
    int step, n, cyc;
    logic [31:0] es, ed;
    logic [2:0] sfc, dfc;
    bit fly, m2p;
    sfc = 3'($urandom_range(0, 7));
    dfc = 3'($urandom_range(0, 7));
    fly = (md == 2'b01) || (md == 2'b10);
    m2p = (md == 2'b10);
    @(negedge clk);
    cfg_mode = md; cfg_size = sz; cfg_src = src; cfg_dst = dst; cfg_count = cnt;
    cfg_src_fc = sfc; cfg_dst_fc = dfc; cfg_src_mem = smem; cfg_dst_mem = dmem;
    irq_en = ie; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (cnt == 0) begin
      chk(done && !busy && !bus_req, "R2", "zero count", {done, busy, bus_req}, 3'b100);
      chk(irq == ie, "R9", "irq zero", irq, ie);
      return;
    end
    chk(busy && !done && !err, "R1", "start state", {busy, done, err}, 3'b100);
    if (probe) begin
      cfg_src = src ^ 32'hFFFF_0000; cfg_size = sz + 2'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    step = nbytes(sz);
    n = (int'(cnt) + step - 1) / step;
    es = src; ed = dst; cyc = 0;
    for (int t = 0; t < n; t++) begin
      repeat ($urandom_range(1, 3)) @(negedge clk);
      chk(!bus_req, "R3", "no cycle without request", bus_req, 0);
      dreq = 1'b1;
      repeat (extra ? 3 : 1) @(negedge clk);
      dreq = 1'b0;
      if (!fly) begin
        serve(probe ? "R1" : "R4", 1'b0, es, sfc, !smem, 1'b0, '0, sz, cyc == err_at);
        if (cyc == err_at) break;
        cyc++;
        serve("R4", 1'b1, ed, dfc, !dmem, 1'b1, pat(es), sz, cyc == err_at);
        if (cyc == err_at) break;
        cyc++;
        if (smem) es += step;
        if (dmem) ed += step;
      end else if (m2p) begin
        serve("R8", 1'b0, es, sfc, 1'b1, 1'b0, '0, sz, cyc == err_at);
        if (cyc == err_at) break;
        cyc++;
        es += step;
      end else begin
        serve("R8", 1'b1, ed, dfc, 1'b1, 1'b0, '0, sz, cyc == err_at);
        if (cyc == err_at) break;
        cyc++;
        ed += step;
      end
      if (t < n - 1)
        chk(busy && !done, "R6", "still running", {busy, done}, 2'b10);
    end
    if (err_at >= 0 && err_at < cyc + 1 && !done) begin
      chk(err && !done && !busy && !irq, "R10", "abort", {err, done, busy, irq}, 4'b1000);
      repeat (3) begin
        @(negedge clk);
        chk(!bus_req, "R10", "quiet after abort", bus_req, 0);
      end
    end else begin
      chk(done && !busy && !err, "R9", "completion", {done, busy, err}, 3'b100);
      chk(irq == ie, "R9", "irq mask", irq, ie);
      repeat (2) begin
        @(negedge clk);
        chk(!bus_req, "R6", "no extra transfer", bus_req, 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4417));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !err && !irq && !bus_req && !dack, "R1", "reset state",
        {busy, done, err, irq, bus_req, dack}, 0);

    // directed corners
    run_job(2'b00, 2'd2, 32'h1000, 32'h2000, 16'd12, 1'b1, 1'b1, 1'b1, -1, 1'b0, 1'b1);
    run_job(2'b00, 2'd0, 32'h0, 32'h0, 16'd0, 1'b1, 1'b1, 1'b1, -1, 1'b0, 1'b0);
    run_job(2'b00, 2'd2, 32'h3000, 32'h4000, 16'd5, 1'b1, 1'b0, 1'b0, -1, 1'b1, 1'b0);
    run_job(2'b01, 2'd3, 32'h0, 32'h8000, 16'd40, 1'b1, 1'b1, 1'b1, -1, 1'b1, 1'b0);
    run_job(2'b10, 2'd1, 32'h9000, 32'h0, 16'd7, 1'b1, 1'b1, 1'b0, -1, 1'b0, 1'b0);
    run_job(2'b00, 2'd0, 32'h500, 32'h600, 16'd3, 1'b0, 1'b1, 1'b1, -1, 1'b0, 1'b0);

    // write-one-to-clear of done
    @(negedge clk);
    clr_done = 1'b1;
    @(negedge clk);
    clr_done = 1'b0;
    chk(!done && !irq, "R11", "clr_done", {done, irq}, 0);

    // abort on the write phase of the second transfer
    run_job(2'b00, 2'd1, 32'hA000, 32'hB000, 16'd8, 1'b1, 1'b1, 1'b1, 3, 1'b0, 1'b0);
    run_job(2'b01, 2'd2, 32'h0, 32'hC000, 16'd8, 1'b1, 1'b1, 1'b1, 0, 1'b0, 1'b0);
    @(negedge clk);
    clr_err = 1'b1;
    @(negedge clk);
    clr_err = 1'b0;
    chk(!err, "R11", "clr_err", err, 0);

    // zero count start also clears a stale error flag
    run_job(2'b01, 2'd2, 32'h0, 32'hC000, 16'd8, 1'b1, 1'b1, 1'b0, 1, 1'b0, 1'b0);
    run_job(2'b10, 2'd0, 32'h0, 32'h0, 16'd0, 1'b1, 1'b1, 1'b0, -1, 1'b0, 1'b0);
    chk(!err, "R1", "start clears err", err, 0);

    // constrained random jobs
    for (int j = 0; j < 30; j++) begin
      run_job(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
              $urandom & 32'hFFFF_FFF0, $urandom & 32'hFFFF_FFF0,
              16'($urandom_range(1, 40)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, 3)) : -1,
              1'($urandom_range(0, 1)), 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule